// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the PHY-side end of a two-wire serial management link. The management clock (MDC) and the incoming data line are sampled with the core clock. Every MDC rising edge shifts one bit into a frame decoder. The decoder waits for a run of at least 32 ones, then checks the start and opcode fields. It compares the 5-bit PHY address with the address latched from the strap pins, then takes the 5-bit register address. A read frame releases the line for the first turnaround bit, drives a zero for the second, and shifts the 16-bit register value out most significant bit first. A write frame collects 16 bits and commits them to the addressed register when the last bit is sampled. All output changes follow MDC falling edges, so the MDC period can be stretched without limit.

A small register bank sits behind the decoder:
- a control word, with a self-clearing reset bit and an auto-negotiation enable that masks the forced speed and duplex bits;
- a status word whose event bits latch until they are read;
- two fixed identifier words;
- a read-only word holding the straps captured at reset.

The core logic sees the control word, the effective forced-mode bits and the captured straps on dedicated outputs.

Top module: `mgmt_reg_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones have been sampled. It is then a 0 followed by a 1 (start), the opcode (10 read, 01 write), the PHY address and the register address, each address sent MSB first. If fewer than 32 ones come before the start 0, the frame is ignored.
- R2: On a read addressed to this slave, mdio_oe stays low during the first turnaround bit. It rises with mdio_o=0 for the second turnaround bit, then carries the 16 data bits MSB first, and it drops after the last data bit. The outputs change only in the core cycle after an MDC falling edge is detected.
- R3: A write updates the control register (address 0) with the 16 data bits. Writes to addresses 1, 2, 3 and 25 have no effect, and neither do writes to any unmapped address. Unmapped addresses read 0.
- R4: A frame whose PHY address differs from the latched address, or whose opcode is 00 or 11, or whose start field is not 01, produces no drive and no write. Decoding resumes only after a new run of 32 ones.
- R5: At reset, the strap pins are captured into register 25: bits 4:0 hold the PHY address, bit 5 the repeater strap and bit 6 the bypass strap. The same values appear on phy_addr_o, rptr_o and byp_o. Changing the pins after reset has no effect.
- R6: The control register resets to 16'h1000 (auto-negotiation enabled). Bit 10 (isolate) is also set when the captured PHY address is 00000.
- R7: Writing 1 to control bit 15 reloads the control default in the next core cycle, so bit 15 reads back as 0. The same reload clears the latched status bits.
- R8: While control bit 12 is 1, speed_o and fdx_o are 0. While it is 0, speed_o follows bit 13 and fdx_o follows bit 8.
- R9: Register 1 reads 16'h7809 OR'ed with the latched jabber bit (bit 1) and the latched remote-fault bit (bit 4). Each latched bit is set by a one-cycle event pulse and holds until a read of register 1 has returned it. A read of register 1 then clears it.
- R10: Registers 2 and 3 return the identifier parameters (defaults 16'h0A5C and 16'h31E2).
- R11: Frames decode correctly whatever the MDC high or low time, including pauses of hundreds of core cycles in mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, also latches straps |
| mdc | input | 1 | Management clock, synchronous to clk |
| mdio_i | input | 1 | Management data line as seen at the pad |
| strap_addr | input | 5 | Strapped PHY address |
| strap_rptr | input | 1 | Strapped repeater mode |
| strap_byp | input | 1 | Strapped bypass option |
| evt_jabber | input | 1 | Jabber event pulse |
| evt_rfault | input | 1 | Remote fault event pulse |
| mdio_o | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Line drive enable |
| ctrl_o | output | 16 | Control register contents |
| speed_o | output | 1 | Effective forced 100 Mb/s select |
| fdx_o | output | 1 | Effective forced full duplex select |
| phy_addr_o | output | 5 | Latched PHY address |
| rptr_o | output | 1 | Latched repeater strap |
| byp_o | output | 1 | Latched bypass strap |

## Verification
Reads of every mapped register and of an unmapped one check the returned words against a behavioural model, bit by bit, together with the drive enable on each bit. A read with a wrong PHY address tells a correct address compare apart from one that answers every frame. Frames with a bad opcode, a bad start field and a 31-one preamble, each followed by a 32-one frame, separate preamble counting from loose start detection. A read with a long MDC low phase separates edge-driven logic from logic that counts core cycles. Event pulses read back twice tell latch-until-read apart from live status or clear-on-any-access. Writes with bit 12 set and clear, and a write of bit 15, tell the forced-mode gating and the self-clear apart from plain storage. A second reset with address 00000, and strap pins changed after the first reset, exercise the capture rules.

// File: rtl/mreg_pkg.sv
package mreg_pkg;

    typedef enum logic [2:0] {
        FS_PRE,
        FS_ST,
        FS_OP,
        FS_PHY,
        FS_REG,
        FS_TA,
        FS_DATA
    } fstate_t;

    typedef struct packed {
        logic        valid;
        logic [4:0]  addr;
        logic [15:0] data;
    } wr_req_t;

    typedef struct packed {
        logic       byp;
        logic       rptr;
        logic [4:0] addr;
    } strap_t;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] RA_CTRL  = 5'd0;
    localparam logic [4:0] RA_STAT  = 5'd1;
    localparam logic [4:0] RA_IDHI  = 5'd2;
    localparam logic [4:0] RA_IDLO  = 5'd3;
    localparam logic [4:0] RA_STRAP = 5'd25;

    localparam int CB_RST = 15;
    localparam int CB_SPD = 13;
    localparam int CB_AN  = 12;
    localparam int CB_ISO = 10;
    localparam int CB_DPX = 8;

    localparam logic [15:0] STAT_FIXED = 16'h7809;
    localparam int NLAT = 2;
    localparam int LAT_POS [NLAT] = '{1, 4};

    function automatic logic [15:0] ctrl_default(input logic [4:0] addr);
        logic [15:0] v;
        v = '0;
        v[CB_AN]  = 1'b1;
        v[CB_ISO] = (addr == 5'd0);
        return v;
    endfunction

endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
    import mreg_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mdc,
    input  logic        mdio_i,
    input  logic [4:0]  my_addr,
    output logic        rd_req,
    output logic [4:0]  rd_addr,
    input  logic [15:0] rd_data,
    output wr_req_t     wr,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam logic [PCW-1:0] PRE_MAX = PCW'(PRE_LEN);

    logic            mdc_q;
    logic            rise, fall;
    fstate_t         st;
    logic [PCW-1:0]  pre_cnt;
    logic [3:0]      cnt;
    logic [15:0]     sh;
    logic            is_rd;
    logic [4:0]      reg_q;
    logic [15:0]     rd_word;
    logic [4:0]      five;
    logic [1:0]      two;
    logic            drive_nxt, bit_nxt;

    assign rise = mdc & ~mdc_q;
    assign fall = ~mdc & mdc_q;
    assign five = {sh[3:0], mdio_i};
    assign two  = {sh[0], mdio_i};

    assign rd_req   = rise && (st == FS_REG) && (cnt == 4'd4) && is_rd;
    assign rd_addr  = five;
    assign wr.valid = rise && (st == FS_DATA) && (cnt == 4'd15) && !is_rd;
    assign wr.addr  = reg_q;
    assign wr.data  = {sh[14:0], mdio_i};

    always_comb begin
        drive_nxt = is_rd && (((st == FS_TA) && (cnt == 4'd1)) || (st == FS_DATA));
        bit_nxt   = (st == FS_DATA) ? rd_word[4'd15 - cnt] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q   <= 1'b0;
            st      <= FS_PRE;
            pre_cnt <= '0;
            cnt     <= '0;
            sh      <= '0;
            is_rd   <= 1'b0;
            reg_q   <= '0;
            rd_word <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            mdc_q <= mdc;
            if (rise) begin
                sh <= {sh[14:0], mdio_i};
                case (st)
                    FS_PRE: begin
                        if (mdio_i) begin
                            if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            if (pre_cnt == PRE_MAX) st <= FS_ST;
                            pre_cnt <= '0;
                        end
                    end
                    FS_ST: begin
                        st  <= mdio_i ? FS_OP : FS_PRE;
                        cnt <= '0;
                    end
                    FS_OP: begin
                        if (cnt == 4'd0) begin
                            cnt <= 4'd1;
                        end else begin
                            cnt <= '0;
                            case (two)
                                OP_RD:   begin is_rd <= 1'b1; st <= FS_PHY; end
                                OP_WR:   begin is_rd <= 1'b0; st <= FS_PHY; end
                                default: st <= FS_PRE;
                            endcase
                        end
                    end
                    FS_PHY: begin
                        if (cnt == 4'd4) begin
                            cnt <= '0;
                            st  <= (five == my_addr) ? FS_REG : FS_PRE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_REG: begin
                        if (cnt == 4'd4) begin
                            cnt   <= '0;
                            reg_q <= five;
                            st    <= FS_TA;
                            if (is_rd) rd_word <= rd_data;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_TA: begin
                        if (cnt == 4'd1) begin
                            cnt <= '0;
                            st  <= FS_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        if (cnt == 4'd15) begin
                            cnt <= '0;
                            st  <= FS_PRE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= FS_PRE;
                endcase
            end
            if (fall) begin
                mdio_oe <= drive_nxt;
                mdio_o  <= drive_nxt & bit_nxt;
            end
        end
    end

endmodule

// File: rtl/mreg_bank.sv
module mreg_bank
    import mreg_pkg::*;
#(
    parameter logic [15:0] ID_HI = 16'h0A5C,
    parameter logic [15:0] ID_LO = 16'h31E2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  strap_addr,
    input  logic        strap_rptr,
    input  logic        strap_byp,
    input  logic        evt_jabber,
    input  logic        evt_rfault,
    input  logic        rd_req,
    input  logic [4:0]  rd_addr,
    output logic [15:0] rd_data,
    input  wr_req_t     wr,
    output logic [15:0] ctrl_o,
    output logic [4:0]  phy_addr_o,
    output logic        rptr_o,
    output logic        byp_o
);
    strap_t          cfg;
    logic [15:0]     ctrl_q;
    logic [NLAT-1:0] lat_q;
    logic [NLAT-1:0] evts;
    logic            lat_clr;
    logic [15:0]     stat_word;

    assign evts    = {evt_rfault, evt_jabber};
    assign lat_clr = (rd_req && (rd_addr == RA_STAT)) || ctrl_q[CB_RST];

    generate
        for (genvar g = 0; g < NLAT; g++) begin : g_lat
            always_ff @(posedge clk) begin
                if (rst) lat_q[g] <= 1'b0;
                else     lat_q[g] <= evts[g] | (lat_q[g] & ~lat_clr);
            end
        end
    endgenerate

    always_comb begin
        stat_word = STAT_FIXED;
        for (int i = 0; i < NLAT; i++) stat_word[LAT_POS[i]] = lat_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '{byp: strap_byp, rptr: strap_rptr, addr: strap_addr};
            ctrl_q <= ctrl_default(strap_addr);
        end else if (ctrl_q[CB_RST]) begin
            ctrl_q <= ctrl_default(cfg.addr);
        end else if (wr.valid && (wr.addr == RA_CTRL)) begin
            ctrl_q <= wr.data;
        end
    end

    always_comb begin
        case (rd_addr)
            RA_CTRL:  rd_data = ctrl_q;
            RA_STAT:  rd_data = stat_word;
            RA_IDHI:  rd_data = ID_HI;
            RA_IDLO:  rd_data = ID_LO;
            RA_STRAP: rd_data = {9'd0, cfg};
            default:  rd_data = '0;
        endcase
    end

    assign ctrl_o     = ctrl_q;
    assign phy_addr_o = cfg.addr;
    assign rptr_o     = cfg.rptr;
    assign byp_o      = cfg.byp;

endmodule

// File: rtl/mgmt_reg_slave.sv
module mgmt_reg_slave
    import mreg_pkg::*;
#(
    parameter int          PRE_LEN = 32,
    parameter logic [15:0] ID_HI   = 16'h0A5C,
    parameter logic [15:0] ID_LO   = 16'h31E2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mdc,
    input  logic        mdio_i,
    input  logic [4:0]  strap_addr,
    input  logic        strap_rptr,
    input  logic        strap_byp,
    input  logic        evt_jabber,
    input  logic        evt_rfault,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] ctrl_o,
    output logic        speed_o,
    output logic        fdx_o,
    output logic [4:0]  phy_addr_o,
    output logic        rptr_o,
    output logic        byp_o
);
    logic        rd_req;
    logic [4:0]  rd_addr;
    logic [15:0] rd_data;
    wr_req_t     wr;

    mdio_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .mdc     (mdc),
        .mdio_i  (mdio_i),
        .my_addr (phy_addr_o),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr      (wr),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mreg_bank #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .strap_addr (strap_addr),
        .strap_rptr (strap_rptr),
        .strap_byp  (strap_byp),
        .evt_jabber (evt_jabber),
        .evt_rfault (evt_rfault),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr         (wr),
        .ctrl_o     (ctrl_o),
        .phy_addr_o (phy_addr_o),
        .rptr_o     (rptr_o),
        .byp_o      (byp_o)
    );

    assign speed_o = ~ctrl_o[CB_AN] & ctrl_o[CB_SPD];
    assign fdx_o   = ~ctrl_o[CB_AN] & ctrl_o[CB_DPX];

endmodule

// File: rtl/mreg_chk.sv
module mreg_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] ctrl_o,
    input logic        speed_o,
    input logic        fdx_o,
    input logic        rptr_o,
    input logic        byp_o
);
    logic mdc_prev;

    always_ff @(posedge clk) begin
        if (rst) mdc_prev <= 1'b0;
        else     mdc_prev <= mdc;
    end

    // R2
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe != $past(mdio_oe)) |-> $past(!mdc && mdc_prev));

    // R2
    ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o);

    // R7
    self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[15] |=> !ctrl_o[15]);

    // R8
    an_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[12] |-> (!speed_o && !fdx_o));

    // R5
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(rptr_o) && $stable(byp_o));

endmodule

bind mgmt_reg_slave mreg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .ctrl_o  (ctrl_o),
    .speed_o (speed_o),
    .fdx_o   (fdx_o),
    .rptr_o  (rptr_o),
    .byp_o   (byp_o)
);

// File: tb/sim_mgmt_reg_slave.sv
module sim_mgmt_reg_slave;
    localparam logic [15:0] IDH = 16'h0A5C;
    localparam logic [15:0] IDL = 16'h31E2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc = 1'b0;
    logic        drv = 1'b1;
    logic        mdio_i;
    logic [4:0]  strap_addr = 5'h05;
    logic        strap_rptr = 1'b1;
    logic        strap_byp  = 1'b0;
    logic        evt_jabber = 1'b0;
    logic        evt_rfault = 1'b0;
    logic        mdio_o, mdio_oe, speed_o, fdx_o, rptr_o, byp_o;
    logic [15:0] ctrl_o;
    logic [4:0]  phy_addr_o;

    int checks = 0;
    int fails  = 0;
    int gap_low = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_ctrl;
    logic        m_jab, m_rf, m_rptr, m_byp;
    logic [4:0]  m_addr;

    always #10 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : drv;

    mgmt_reg_slave u0 (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
        .strap_addr(strap_addr), .strap_rptr(strap_rptr), .strap_byp(strap_byp),
        .evt_jabber(evt_jabber), .evt_rfault(evt_rfault),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .ctrl_o(ctrl_o),
        .speed_o(speed_o), .fdx_o(fdx_o), .phy_addr_o(phy_addr_o),
        .rptr_o(rptr_o), .byp_o(byp_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [4:0] ra);
        case (ra)
            5'd0:    return m_ctrl;
            5'd1:    return 16'h7809 | {11'd0, m_rf, 2'b00, m_jab, 1'b0};
            5'd2:    return IDH;
            5'd3:    return IDL;
            5'd25:   return {9'd0, m_byp, m_rptr, m_addr};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] m_default(input logic [4:0] a);
        return 16'h1000 | ((a == 5'd0) ? 16'h0400 : 16'h0000);
    endfunction

    // every-clock comparison of the control outputs against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R8 clk ctrl", ctrl_o, m_ctrl);
            chk("R8 clk speed/dpx", {14'd0, speed_o, fdx_o},
                {14'd0, ~m_ctrl[12] & m_ctrl[13], ~m_ctrl[12] & m_ctrl[8]});
        end
    end

    task automatic send_bit(input logic b, output logic s_oe, output logic s_o);
        @(negedge clk);
        mdc = 1'b0;
        drv = b;
        repeat (3 + gap_low) @(negedge clk);
        s_oe = mdio_oe;
        s_o  = mdio_o;
        @(negedge clk);
        mdc = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input int npre, input logic [1:0] stv, input logic [1:0] opv,
                         input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                         input bit exp_drv, output logic [15:0] rd, output bit ok);
        logic so, sv;
        logic [13:0] head;
        bit is_wr;
        head  = {stv, opv, pa, ra};
        is_wr = (opv == 2'b01);
        ok = 1'b1;
        rd = '0;
        for (int i = 0; i < npre; i++) begin send_bit(1'b1, so, sv); if (so) ok = 1'b0; end
        for (int i = 13; i >= 0; i--) begin send_bit(head[i], so, sv); if (so) ok = 1'b0; end
        send_bit(1'b1, so, sv);
        if (so) ok = 1'b0;
        send_bit(is_wr ? 1'b0 : 1'b1, so, sv);
        if (exp_drv ? !(so && !sv) : so) ok = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            send_bit(is_wr ? wd[i] : 1'b1, so, sv);
            rd[i] = sv;
            if (exp_drv ? !so : so) ok = 1'b0;
        end
        send_bit(1'b1, so, sv);
        if (so) ok = 1'b0;
    endtask

    task automatic mwrite(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] rd;
        bit ok;
        cmp_en = 1'b0;
        frame(32, 2'b01, 2'b01, pa, ra, wd, 1'b0, rd, ok);
        chk("R4 no drive on write", {15'd0, ok}, 16'd1);
        if (pa == m_addr && ra == 5'd0) begin
            if (wd[15]) begin
                m_ctrl = m_default(m_addr);
                m_jab = 1'b0;
                m_rf = 1'b0;
            end else begin
                m_ctrl = wd;
            end
        end
        cmp_en = 1'b1;
    endtask

    task automatic mread(input string req, input logic [4:0] pa, input logic [4:0] ra);
        logic [15:0] rd;
        bit ok;
        bit hit;
        hit = (pa == m_addr);
        frame(32, 2'b01, 2'b10, pa, ra, 16'h0, hit, rd, ok);
        chk({req, " R2 drive"}, {15'd0, ok}, 16'd1);
        if (hit) begin
            chk(req, rd, m_read(ra));
            if (ra == 5'd1) begin m_jab = 1'b0; m_rf = 1'b0; end
        end
    endtask

    task automatic do_reset(input logic [4:0] a, input logic rp, input logic bp);
        cmp_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        strap_addr = a;
        strap_rptr = rp;
        strap_byp = bp;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_addr = a; m_rptr = rp; m_byp = bp;
        m_ctrl = m_default(a);
        m_jab = 1'b0; m_rf = 1'b0;
        @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        logic so, sv;
        bit ok;

        do_reset(5'h05, 1'b1, 1'b0);
        // R6: reset value with a non-zero address
        chk("R6 reset ctrl", ctrl_o, 16'h1000);
        chk("R5 strap outs", {9'd0, byp_o, rptr_o, phy_addr_o}, 16'h0025);

        // R10 identifier words
        mread("R10 id hi", 5'h05, 5'd2);
        mread("R10 id lo", 5'h05, 5'd3);

        // R5 strap register, then pins moved without a reset
        mread("R5 strap reg", 5'h05, 5'd25);
        strap_addr = 5'h09; strap_rptr = 1'b0; strap_byp = 1'b1;
        repeat (5) @(negedge clk);
        mread("R5 strap after pin change", 5'h05, 5'd25);
        chk("R5 rptr_o held", {15'd0, rptr_o}, 16'd1);

        // R3 / R8 forced mode, auto-negotiation off
        mwrite(5'h05, 5'd0, 16'h2100);
        mread("R3 ctrl readback", 5'h05, 5'd0);
        chk("R8 forced speed/dpx", {14'd0, speed_o, fdx_o}, 16'd3);
        // R8 auto-negotiation on masks them
        mwrite(5'h05, 5'd0, 16'h3100);
        chk("R8 masked speed/dpx", {14'd0, speed_o, fdx_o}, 16'd0);

        // R3 read-only and unmapped writes
        mwrite(5'h05, 5'd2, 16'hFFFF);
        mread("R3 id after write", 5'h05, 5'd2);
        mwrite(5'h05, 5'd7, 16'hBEEF);
        mread("R3 unmapped", 5'h05, 5'd7);
        mwrite(5'h05, 5'd25, 16'h007F);
        mread("R3 strap after write", 5'h05, 5'd25);

        // R9 latch until read
        @(negedge clk) evt_jabber = 1'b1;
        @(negedge clk) evt_jabber = 1'b0;
        m_jab = 1'b1;
        mread("R9 jabber latched", 5'h05, 5'd1);
        mread("R9 jabber cleared", 5'h05, 5'd1);
        @(negedge clk) evt_rfault = 1'b1;
        @(negedge clk) evt_rfault = 1'b0;
        m_rf = 1'b1;
        repeat (50) @(negedge clk);
        mread("R9 rfault latched", 5'h05, 5'd1);

        // R7 self-clearing reset
        @(negedge clk) evt_jabber = 1'b1;
        @(negedge clk) evt_jabber = 1'b0;
        m_jab = 1'b1;
        mwrite(5'h05, 5'd0, 16'h0000);
        mwrite(5'h05, 5'd0, 16'h8000);
        chk("R7 ctrl default", ctrl_o, 16'h1000);
        mread("R7 ctrl readback", 5'h05, 5'd0);
        mread("R7 status cleared", 5'h05, 5'd1);

        // R4 wrong PHY address
        mread("R4 foreign read", 5'h06, 5'd0);
        mwrite(5'h06, 5'd0, 16'h0000);
        mread("R4 after foreign write", 5'h05, 5'd0);

        // R4 bad opcode then a short-preamble frame
        cmp_en = 1'b0;
        frame(32, 2'b01, 2'b11, 5'h05, 5'd0, 16'h0000, 1'b0, rd, ok);
        chk("R4 bad op no drive", {15'd0, ok}, 16'd1);
        frame(8, 2'b01, 2'b01, 5'h05, 5'd0, 16'h0000, 1'b0, rd, ok);
        cmp_en = 1'b1;
        mread("R4 ignored after bad op", 5'h05, 5'd0);

        // R4 bad start field
        cmp_en = 1'b0;
        frame(32, 2'b00, 2'b01, 5'h05, 5'd0, 16'h0000, 1'b0, rd, ok);
        cmp_en = 1'b1;
        mread("R4 bad start ignored", 5'h05, 5'd0);

        // R1 preamble boundary: 31 ones ignored, 32 accepted
        send_bit(1'b0, so, sv);
        cmp_en = 1'b0;
        frame(31, 2'b01, 2'b01, 5'h05, 5'd0, 16'h0000, 1'b0, rd, ok);
        cmp_en = 1'b1;
        mread("R1 31 ones ignored", 5'h05, 5'd0);
        send_bit(1'b0, so, sv);
        mwrite(5'h05, 5'd0, 16'h0100);
        mread("R1 32 ones accepted", 5'h05, 5'd0);

        // R11 long MDC low phases
        gap_low = 150;
        mread("R11 stretched id", 5'h05, 5'd3);
        gap_low = 0;

        // R6 address 00000 sets isolate
        do_reset(5'h00, 1'b0, 1'b1);
        chk("R6 isolate at reset", ctrl_o, 16'h1400);
        mread("R6 ctrl addr0", 5'h00, 5'd0);
        mread("R5 strap second", 5'h00, 5'd25);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule